// File: doc/BRIEF.md
# Power-Down Wake-Up Sequencer

This block decides when a microcontroller core may leave its power-down state and how it comes back. Software sets a power-down flag with a one-cycle `pd_set` pulse. The sequencer then turns the main oscillator off and gates the CPU clock. It keeps watching four external interrupt lines, fifteen wake-capable GPIO pins and the external reset pin.

All inputs are sampled on `clk`. This is an always-running low-power sampling clock. Every pin passes through a two-stage synchroniser before its edges are detected. While `osc_en` is high and the core clock is still gated, the stabilisation counter counts `clk` cycles. This stands in for the restarted oscillator settling.

There are two wake timing modes. In counter mode (`wake_mode`=0) the core clock is released after a fixed count. In pin mode (`wake_mode`=1) an interrupt wake is released when the same pin returns high. Each wake source has its own kind of exit:
- An interrupt wake raises a one-cycle interrupt request that carries the pin number.
- A GPIO wake raises a one-cycle resume pulse and no interrupt.
- A reset wake hands the core a held reset that lasts until the reset pin falls.

The power-down flag clears itself when a wake sequence completes. There is no data stream through the block. Every port is a plain control or status signal.

Top module: `pdw_sequencer`

## Requirements
- R1: After `rst_n` the block is running: `osc_en`=1, `cpu_clk_en`=1, `pd_flag`=0, `pof`=1, `wake_src`=0, `core_rst`=0.
- R2: A `pd_set` pulse while running (and while `core_rst` is low) sets `pd_flag` and drops both `osc_en` and `cpu_clk_en` from the next cycle on.
- R3: In power-down with `wake_mode`=0, a high-to-low edge on an interrupt line whose `int_en` bit is set has the following effect:
  - `osc_en` rises.
  - `cpu_clk_en` stays low for exactly STAB_CYCLES cycles with `osc_en` high.
  - `cpu_clk_en` then rises together with a one-cycle `irq_req`.
  - `irq_id` gives the line: 0 = port-3 bit 2, 1 = port-3 bit 3, 2 = `p4_int_pin[0]`, 3 = `p4_int_pin[1]`.
- R4: With `wake_mode`=1, an interrupt wake restarts the oscillator but holds `cpu_clk_en` low until the waking line rises again, however long that takes. `irq_req` is raised with the clock release.
- R5: In power-down, a rising edge on `rst_pin` starts the counter sequence (STAB_CYCLES gated cycles). The clock is then released with `core_rst` held high until `rst_pin` falls. No `irq_req` and no `resume` are raised.
- R6: A high-to-low edge on a GPIO pin whose wake-enable bit is set starts the counter sequence. Completion gives a one-cycle `resume` and no `irq_req`.
- R7: Edges on pins whose enable bit is clear cause no wake: `osc_en` stays 0 and `pd_flag` stays 1. Port-3 bit 6 can never wake, whatever its enable bit.
- R8: Port-3 bits 2 and 3 wake as GPIO through `p3_wk_en` even when their interrupt enable is clear.
- R9: The port-4 lines (`p4_int_pin`) have no GPIO wake path. They wake only when their `int_en` bit (2 or 3) is set.
- R10: `pd_flag` is cleared by hardware in the cycle the CPU clock is released after a wake.
- R11: `wake_src` shows the source of the most recent wake (0 none, 1 interrupt, 2 reset, 3 GPIO). It keeps its value through a later power-down until another wake happens.
- R12: `pof` is set only by `rst_n`. It is cleared by `pof_clr` and is not changed by `rst_pin` resets.
- R13: Wake causes that arrive in the same cycle are resolved by priority: reset wins over interrupt, and interrupt wins over GPIO.
- R14: In pin mode, a rising edge on any interrupt line other than the one that woke the device does not release the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sampling clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin | input | 1 | External reset pin, active high |
| pd_set | input | 1 | Software request to enter power-down (pulse) |
| pof_clr | input | 1 | Clears the power-on flag |
| wake_mode | input | 1 | 0: counter-timed wake, 1: pin-timed interrupt wake |
| int_en | input | 4 | Interrupt enables for lines 0..3 |
| p1_pin | input | 8 | Port-1 pins |
| p3_pin | input | 8 | Port-3 pins (bit 2 and bit 3 double as interrupt lines 0 and 1) |
| p4_int_pin | input | 2 | Port-4 interrupt lines 2 and 3 |
| p1_wk_en | input | 8 | Port-1 wake enables |
| p3_wk_en | input | 8 | Port-3 wake enables (bit 6 has no effect) |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | Core clock gate enable |
| core_rst | output | 1 | Reset to the core |
| irq_req | output | 1 | One-cycle interrupt request after an interrupt wake |
| irq_id | output | 2 | Line number for `irq_req` |
| resume | output | 1 | One-cycle resume pulse after a GPIO wake |
| pd_flag | output | 1 | Power-down flag |
| pof | output | 1 | Power-on flag |
| wake_src | output | 2 | Most recent wake source |

## Verification
Two pairs of wake causes can land on the same sampling edge in power-down.

The first pair is a reset rise together with an enabled interrupt fall. The bench drives `rst_pin` high and port-3 bit 2 low on the same clock phase. Both pass through identical synchronisers, so the two edges reach the sequencer together. The case is judged by `wake_src` reading reset, by no `irq_req` ever appearing, and by `core_rst` being held after the clock is released.

The second pair is a pin that carries both an enabled interrupt and an enabled GPIO wake. A single fall on that pin triggers both. This must yield an interrupt wake with the right `irq_id` and no `resume`.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  localparam int NUM_INT = 4;
  localparam int IDW     = $clog2(NUM_INT);
  localparam int P4_W    = NUM_INT - 2;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_CNT,
    ST_PIN,
    ST_RHOLD
  } pdw_state_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_INT  = 2'd1,
    SRC_RST  = 2'd2,
    SRC_GPIO = 2'd3
  } pdw_src_e;
endpackage

// File: rtl/pdw_edge_sync.sv
module pdw_edge_sync #(
  parameter int           W    = 1,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_d
);
  // two synchroniser stages plus one history stage per pin
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= IDLE[b];
        s2 <= IDLE[b];
        s3 <= IDLE[b];
      end else begin
        s1 <= din[b];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl[b]   = s2;
    assign lvl_d[b] = s3;
  end
endmodule

// File: rtl/pdw_wake_select.sv
module pdw_wake_select
  import pdw_pkg::*;
#(
  parameter int            P1_W         = 8,
  parameter int            P3_W         = 8,
  parameter logic [P3_W-1:0] P3_WAKE_MASK = 8'hBF,
  parameter int            INT0_BIT     = 2,
  parameter int            INT1_BIT     = 3
) (
  input  logic [P1_W-1:0]    p1_fall,
  input  logic [P3_W-1:0]    p3_fall,
  input  logic [P4_W-1:0]    p4_fall,
  input  logic               rst_rise,
  input  logic [NUM_INT-1:0] int_en,
  input  logic [P1_W-1:0]    p1_en,
  input  logic [P3_W-1:0]    p3_en,
  output logic               fire,
  output pdw_src_e           kind,
  output logic [IDW-1:0]     id
);
  logic [NUM_INT-1:0] int_fall, int_hit;
  logic               gpio_hit;

  assign int_fall = {p4_fall, p3_fall[INT1_BIT], p3_fall[INT0_BIT]};
  assign int_hit  = int_fall & int_en;
  assign gpio_hit = (|(p1_fall & p1_en)) | (|(p3_fall & p3_en & P3_WAKE_MASK));

  always_comb begin
    id = '0;
    for (int k = NUM_INT - 1; k >= 0; k--) begin
      if (int_hit[k]) id = IDW'(k);
    end
  end

  // priority: reset, then interrupt lines, then plain GPIO
  always_comb begin
    fire = 1'b1;
    if (rst_rise)       kind = SRC_RST;
    else if (|int_hit)  kind = SRC_INT;
    else if (gpio_hit)  kind = SRC_GPIO;
    else begin
      kind = SRC_NONE;
      fire = 1'b0;
    end
  end
endmodule

// File: rtl/pdw_stab_timer.sv
module pdw_stab_timer #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  logic [CW-1:0] cnt;

  assign done = run && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || done)  cnt <= '0;
    else                    cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/pdw_sequencer.sv
module pdw_sequencer
  import pdw_pkg::*;
#(
  parameter int              STAB_CYCLES  = 1024,
  parameter int              P1_W         = 8,
  parameter int              P3_W         = 8,
  parameter logic [P3_W-1:0] P3_WAKE_MASK = 8'hBF,
  parameter int              INT0_BIT     = 2,
  parameter int              INT1_BIT     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_pin,
  input  logic               pd_set,
  input  logic               pof_clr,
  input  logic               wake_mode,
  input  logic [NUM_INT-1:0] int_en,
  input  logic [P1_W-1:0]    p1_pin,
  input  logic [P3_W-1:0]    p3_pin,
  input  logic [P4_W-1:0]    p4_int_pin,
  input  logic [P1_W-1:0]    p1_wk_en,
  input  logic [P3_W-1:0]    p3_wk_en,
  output logic               osc_en,
  output logic               cpu_clk_en,
  output logic               core_rst,
  output logic               irq_req,
  output logic [IDW-1:0]     irq_id,
  output logic               resume,
  output logic               pd_flag,
  output logic               pof,
  output logic [1:0]         wake_src
);
  logic [P1_W-1:0]    p1_l, p1_d, p1_fall;
  logic [P3_W-1:0]    p3_l, p3_d, p3_fall;
  logic [P4_W-1:0]    p4_l, p4_d, p4_fall;
  logic               rst_l, rst_d, rst_rise;
  logic [NUM_INT-1:0] int_rise;

  pdw_edge_sync #(.W(P1_W), .IDLE({P1_W{1'b1}})) i_sync_p1 (
    .clk(clk), .rst_n(rst_n), .din(p1_pin), .lvl(p1_l), .lvl_d(p1_d));
  pdw_edge_sync #(.W(P3_W), .IDLE({P3_W{1'b1}})) i_sync_p3 (
    .clk(clk), .rst_n(rst_n), .din(p3_pin), .lvl(p3_l), .lvl_d(p3_d));
  pdw_edge_sync #(.W(P4_W), .IDLE({P4_W{1'b1}})) i_sync_p4 (
    .clk(clk), .rst_n(rst_n), .din(p4_int_pin), .lvl(p4_l), .lvl_d(p4_d));
  pdw_edge_sync #(.W(1), .IDLE(1'b0)) i_sync_rst (
    .clk(clk), .rst_n(rst_n), .din(rst_pin), .lvl(rst_l), .lvl_d(rst_d));

  assign p1_fall  = ~p1_l & p1_d;
  assign p3_fall  = ~p3_l & p3_d;
  assign p4_fall  = ~p4_l & p4_d;
  assign rst_rise = rst_l & ~rst_d;
  assign int_rise = {p4_l & ~p4_d,
                     p3_l[INT1_BIT] & ~p3_d[INT1_BIT],
                     p3_l[INT0_BIT] & ~p3_d[INT0_BIT]};

  logic           w_fire;
  pdw_src_e       w_kind;
  logic [IDW-1:0] w_id;

  pdw_wake_select #(
    .P1_W(P1_W), .P3_W(P3_W), .P3_WAKE_MASK(P3_WAKE_MASK),
    .INT0_BIT(INT0_BIT), .INT1_BIT(INT1_BIT)
  ) i_sel (
    .p1_fall(p1_fall), .p3_fall(p3_fall), .p4_fall(p4_fall),
    .rst_rise(rst_rise), .int_en(int_en),
    .p1_en(p1_wk_en), .p3_en(p3_wk_en),
    .fire(w_fire), .kind(w_kind), .id(w_id));

  pdw_state_e     state;
  pdw_src_e       src_q;
  logic [IDW-1:0] sel_q, id_q;
  logic           pd_q, pof_q, irq_q, res_q, stab_done;

  pdw_stab_timer #(.CYCLES(STAB_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_CNT), .done(stab_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      src_q <= SRC_NONE;
      sel_q <= '0;
      id_q  <= '0;
      pd_q  <= 1'b0;
      pof_q <= 1'b1;
      irq_q <= 1'b0;
      res_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      res_q <= 1'b0;
      if (pof_clr) pof_q <= 1'b0;
      case (state)
        ST_RUN: begin
          if (rst_l) pd_q <= 1'b0;
          else if (pd_set) begin
            pd_q  <= 1'b1;
            state <= ST_SLEEP;
          end
        end
        ST_SLEEP: begin
          if (w_fire) begin
            src_q <= w_kind;
            sel_q <= w_id;
            state <= (w_kind == SRC_INT && wake_mode) ? ST_PIN : ST_CNT;
          end
        end
        ST_CNT: begin
          if (stab_done) begin
            pd_q <= 1'b0;
            if (src_q == SRC_RST) state <= ST_RHOLD;
            else begin
              state <= ST_RUN;
              irq_q <= (src_q == SRC_INT);
              res_q <= (src_q == SRC_GPIO);
              id_q  <= sel_q;
            end
          end
        end
        ST_PIN: begin
          if (int_rise[sel_q]) begin
            pd_q  <= 1'b0;
            state <= ST_RUN;
            irq_q <= 1'b1;
            id_q  <= sel_q;
          end
        end
        ST_RHOLD: begin
          if (!rst_l) state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign osc_en     = (state != ST_SLEEP);
  assign cpu_clk_en = (state == ST_RUN) || (state == ST_RHOLD);
  assign core_rst   = rst_l || (state == ST_RHOLD);
  assign irq_req    = irq_q;
  assign irq_id     = id_q;
  assign resume     = res_q;
  assign pd_flag    = pd_q;
  assign pof        = pof_q;
  assign wake_src   = src_q;
endmodule

// File: rtl/pdw_checker.sv
module pdw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pof_clr,
  input logic       osc_en,
  input logic       cpu_clk_en,
  input logic       core_rst,
  input logic       irq_req,
  input logic       resume,
  input logic       pd_flag,
  input logic       pof,
  input logic [1:0] wake_src
);
  // R2: entering power-down stops oscillator and core clock
  a_r2_sleep_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_flag) |-> (!osc_en && !cpu_clk_en));

  // R3: interrupt request only after an interrupt wake, with the clock running
  a_r3_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (wake_src == 2'd1 && cpu_clk_en));

  // R6: resume only after a GPIO wake and never with an interrupt
  a_r6_resume_src: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (wake_src == 2'd3 && !irq_req));

  // R5: reset wakes give neither interrupt nor resume
  a_r5_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_src == 2'd2) |-> (!irq_req && !resume));

  // R10: clock release clears the power-down flag
  a_r10_pd_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> !pd_flag);

  // R12: power-on flag only falls on an explicit clear
  a_r12_pof_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pof && !pof_clr) |=> pof);

  // R5: core reset is never released while the clock is still gated after wake
  a_r5_rst_clk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst && !cpu_clk_en) |-> osc_en || pd_flag);
endmodule

bind pdw_sequencer pdw_checker i_pdw_checker (
  .clk(clk), .rst_n(rst_n), .pof_clr(pof_clr), .osc_en(osc_en),
  .cpu_clk_en(cpu_clk_en), .core_rst(core_rst), .irq_req(irq_req),
  .resume(resume), .pd_flag(pd_flag), .pof(pof), .wake_src(wake_src));

// File: tb/test_pdw_sequencer.sv
module test_pdw_sequencer;
  localparam int STAB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_pin = 1'b0, pd_set = 1'b0, pof_clr = 1'b0, wake_mode = 1'b0;
  logic [3:0] int_en = '0;
  logic [7:0] p1_pin = 8'hFF, p3_pin = 8'hFF;
  logic [1:0] p4_int_pin = 2'b11;
  logic [7:0] p1_wk_en = '0, p3_wk_en = '0;
  logic       osc_en, cpu_clk_en, core_rst, irq_req, resume, pd_flag, pof;
  logic [1:0] irq_id, wake_src;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pdw_sequencer #(.STAB_CYCLES(STAB)) i_pdw_sequencer (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .pd_set(pd_set),
    .pof_clr(pof_clr), .wake_mode(wake_mode), .int_en(int_en),
    .p1_pin(p1_pin), .p3_pin(p3_pin), .p4_int_pin(p4_int_pin),
    .p1_wk_en(p1_wk_en), .p3_wk_en(p3_wk_en), .osc_en(osc_en),
    .cpu_clk_en(cpu_clk_en), .core_rst(core_rst), .irq_req(irq_req),
    .irq_id(irq_id), .resume(resume), .pd_flag(pd_flag), .pof(pof),
    .wake_src(wake_src));

  typedef struct packed {
    logic [3:0] ie;
    logic [7:0] p1e;
    logic [7:0] p3e;
    logic       mode;
    logic [4:0] drop;   // 0-7 port1 bit, 8-15 port3 bit, 16-17 port4 line, 18 reset
    logic       wake;
    logic [1:0] src;
    logic       irq;
    logic [1:0] id;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{4'b0001, 8'h00, 8'h00, 1'b0, 5'd10, 1'b1, 2'd1, 1'b1, 2'd0}, // R3 line 0
    '{4'b0010, 8'h00, 8'h00, 1'b1, 5'd11, 1'b1, 2'd1, 1'b1, 2'd1}, // R4 line 1
    '{4'b0100, 8'h00, 8'h00, 1'b0, 5'd16, 1'b1, 2'd1, 1'b1, 2'd2}, // R9 line 2 enabled
    '{4'b1000, 8'h00, 8'h00, 1'b1, 5'd17, 1'b1, 2'd1, 1'b1, 2'd3}, // R4 line 3
    '{4'b0000, 8'hFF, 8'hFF, 1'b0, 5'd17, 1'b0, 2'd0, 1'b0, 2'd0}, // R9 line 3 disabled
    '{4'b0000, 8'h20, 8'h00, 1'b0, 5'd5,  1'b1, 2'd3, 1'b0, 2'd0}, // R6 port1 bit 5
    '{4'b0000, 8'h00, 8'h80, 1'b0, 5'd15, 1'b1, 2'd3, 1'b0, 2'd0}, // R6 port3 bit 7
    '{4'b0000, 8'h00, 8'h40, 1'b0, 5'd14, 1'b0, 2'd0, 1'b0, 2'd0}, // R7 port3 bit 6
    '{4'b0000, 8'h00, 8'h04, 1'b0, 5'd10, 1'b1, 2'd3, 1'b0, 2'd0}, // R8 int0 off, GPIO on
    '{4'b0000, 8'hFE, 8'h00, 1'b0, 5'd0,  1'b0, 2'd0, 1'b0, 2'd0}, // R7 port1 bit 0 off
    '{4'b0010, 8'h00, 8'h08, 1'b0, 5'd11, 1'b1, 2'd1, 1'b1, 2'd1}, // R13 int over GPIO
    '{4'b0000, 8'h00, 8'h00, 1'b0, 5'd18, 1'b1, 2'd2, 1'b0, 2'd0}  // R5 reset wake
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input vec_t v);
    if (!v.wake) return "R7";
    if (v.src == 2'd2) return "R5";
    if (v.src == 2'd3) return "R6";
    return v.mode ? "R4" : "R3";
  endfunction

  task automatic set_line(input logic [4:0] code, input logic active);
    if (code < 8)       p1_pin[code[2:0]] = ~active;
    else if (code < 16) p3_pin[code[2:0]] = ~active;
    else if (code < 18) p4_int_pin[code[0]] = ~active;
    else                rst_pin = active;
  endtask

  task automatic enter_pd();
    @(negedge clk) pd_set = 1'b1;
    @(negedge clk) pd_set = 1'b0;
    chk("R2 osc_en", osc_en, 1'b0);
    chk("R2 cpu_clk_en", cpu_clk_en, 1'b0);
    chk("R2 pd_flag", pd_flag, 1'b1);
  endtask

  task automatic recover();
    rst_pin = 1'b1;
    for (int i = 0; i < 8 * STAB; i++) begin
      @(negedge clk);
      if (cpu_clk_en && core_rst) break;
    end
    rst_pin = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int   gated = 0, hold = 0, stable = 0, limit;
    logic irq_seen = 1'b0, res_seen = 1'b0, hold_seen = 1'b0, low = 1'b1;
    logic [1:0] id_seen = '0;
    string r = req_of(v);
    @(negedge clk);
    int_en = v.ie; p1_wk_en = v.p1e; p3_wk_en = v.p3e; wake_mode = v.mode;
    enter_pd();
    set_line(v.drop, 1'b1);
    limit = v.wake ? 8 * STAB + 100 : 60;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (osc_en && !cpu_clk_en) gated++;
      if (irq_req) begin irq_seen = 1'b1; id_seen = irq_id; end
      if (resume) res_seen = 1'b1;
      if (cpu_clk_en && core_rst) begin hold_seen = 1'b1; hold++; end
      if (low) begin
        if (v.drop == 5'd18) begin
          if (hold == 5) begin set_line(v.drop, 1'b0); low = 1'b0; end
        end else if (v.mode) begin
          if (gated == 30) begin set_line(v.drop, 1'b0); low = 1'b0; end
        end else if (i == 3) begin
          set_line(v.drop, 1'b0); low = 1'b0;
        end
      end
      if (!low && cpu_clk_en && !core_rst) stable++;
      if (stable == 3) break;
    end
    if (v.wake) begin
      if (v.mode) chk({r, " gated past counter"}, 32'(gated > STAB), 1);
      else        chk({r, " gated cycles"}, gated, STAB);
      chk({r, " irq_req"}, irq_seen, v.irq);
      if (v.irq) chk({r, " irq_id"}, id_seen, v.id);
      chk({r, " resume"}, res_seen, (v.src == 2'd3));
      chk({r, " R11 wake_src"}, wake_src, v.src);
      chk({r, " R10 pd_flag"}, pd_flag, 1'b0);
      if (v.src == 2'd2) chk("R5 core_rst held", hold_seen, 1'b1);
    end else begin
      chk({r, " osc_en"}, osc_en, 1'b0);
      chk({r, " pd_flag"}, pd_flag, 1'b1);
      chk({r, " gated"}, gated, 0);
      recover();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 osc_en", osc_en, 1'b1);
    chk("R1 cpu_clk_en", cpu_clk_en, 1'b1);
    chk("R1 pd_flag", pd_flag, 1'b0);
    chk("R1 pof", pof, 1'b1);
    chk("R1 wake_src", wake_src, 2'd0);
    chk("R1 core_rst", core_rst, 1'b0);

    for (int n = 0; n < NV; n++) run_vec(VT[n]);

    // R11: status survives a new power-down until another wake
    run_vec(VT[5]);
    enter_pd();
    repeat (10) @(negedge clk);
    chk("R11 wake_src held", wake_src, 2'd3);
    recover();

    // R13: reset and interrupt edges in the same cycle; reset wins
    begin
      logic irq_seen = 1'b0;
      int hold = 0;
      @(negedge clk);
      int_en = 4'b0001; p1_wk_en = '0; p3_wk_en = '0; wake_mode = 1'b0;
      enter_pd();
      p3_pin[2] = 1'b0; rst_pin = 1'b1;
      for (int i = 0; i < 8 * STAB; i++) begin
        @(negedge clk);
        if (irq_req) irq_seen = 1'b1;
        if (i == 3) p3_pin[2] = 1'b1;
        if (cpu_clk_en && core_rst) hold++;
        if (hold == 5) rst_pin = 1'b0;
        if (rst_pin == 1'b0 && cpu_clk_en && !core_rst) break;
      end
      chk("R13 wake_src reset", wake_src, 2'd2);
      chk("R13 no irq", irq_seen, 1'b0);
      chk("R13 hold seen", 32'(hold >= 5), 1);
    end

    // R14: another line rising does not release a pin-timed wake
    begin
      logic irq_seen = 1'b0;
      logic [1:0] id_seen = '0;
      @(negedge clk);
      int_en = 4'b0110; wake_mode = 1'b1;
      enter_pd();
      p4_int_pin[0] = 1'b0;
      repeat (10) @(negedge clk);
      p3_pin[3] = 1'b0;
      repeat (5) @(negedge clk);
      p3_pin[3] = 1'b1;
      repeat (10) @(negedge clk);
      chk("R14 clock still gated", cpu_clk_en, 1'b0);
      chk("R14 oscillator on", osc_en, 1'b1);
      p4_int_pin[0] = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (irq_req) begin irq_seen = 1'b1; id_seen = irq_id; end
      end
      chk("R14 irq after own line", irq_seen, 1'b1);
      chk("R14 irq_id", id_seen, 2'd2);
      wake_mode = 1'b0;
    end

    // R12: power-on flag
    @(negedge clk) pof_clr = 1'b1;
    @(negedge clk) pof_clr = 1'b0;
    chk("R12 pof cleared", pof, 1'b0);
    rst_pin = 1'b1;
    repeat (6) @(negedge clk);
    chk("R12 core_rst from pin", core_rst, 1'b1);
    rst_pin = 1'b0;
    repeat (6) @(negedge clk);
    chk("R12 pof kept over pin reset", pof, 1'b0);
    rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R12 pof set by power-on", pof, 1'b1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule